// File: doc/BRIEF.md
# Multi-Level Wavelet Pyramid Slot Scheduler

This controller lets one row filter and one column filter serve every decomposition level of a multi-level 2-D wavelet transform. Time is divided into slots in a repeating frame of 2^LEVELS slots. Level 1 owns every other slot and level 2 every fourth slot. In general, level j owns the slots whose index modulo 2^j equals 2^(j-1). The slot whose index is zero modulo 2^LEVELS belongs to no level and is always idle.

Each level has its own small operand queue. Raster pixels feed the level 1 queue. The low-low result of level k comes back through the feedback port and feeds the level k+1 queue. In a slot owned by a level whose queue holds at least two entries, the scheduler pops the two oldest entries and presents them to the shared filters. In that slot it also gives the level tag, a one-hot select for that level's delay-register bank, and a routing flag. The routing flag says whether the filtered low-low result goes back to the next level or leaves the block. Any other slot is a bubble.

Because level 1 consumes two samples every other slot, the scheduler sustains an average of one input per clock. Each deeper level carries a quarter of the data of the level above it. The filter arithmetic lives outside this block.

Top module: `rpa_sched`

## Requirements
- R1: While rst_ni is low, lvl_o is 0, bubble_o is 1, and bank_sel_o, op_a_o, op_b_o, to_next_o and to_out_o are all 0.
- R2: A slot counter starts at 0 after reset and advances by one each clock, modulo 2^LEVELS. In slot s, the only level that may be issued is the level j for which s mod 2^j = 2^(j-1). Slot 0 is always a bubble.
- R3: The level owning a slot is issued only if its queue held at least two entries before that clock edge. Entries pushed at the same edge do not count. If the queue holds fewer, the slot is a bubble and the queue is left untouched.
- R4: An issue pops the two oldest entries of the level's queue. op_a_o carries the older entry and op_b_o the newer, so each level keeps its arrival order.
- R5: bank_sel_o is one-hot, with bit j-1 set when level j is issued. It is all zeros in a bubble.
- R6: to_next_o is 1 when a level below LEVELS is issued. to_out_o is 1 when level LEVELS is issued. Both are 0 in a bubble.
- R7: bubble_o is 1 exactly when lvl_o is 0. Issued levels are tagged 1 to LEVELS.
- R8: A decision made at a rising edge shows on the outputs from that edge until the next one.
- R9: A pixel with pix_valid_i high enters the level 1 queue. A sample with ll_valid_i high and ll_lvl_i = k, where k is 1 to LEVELS-1, enters the level k+1 queue.
- R10: An N-by-N frame fed back at one low-low sample per four samples consumed issues N²/2 pairs at level 1, and N²/(2·4^(j-1)) pairs at level j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel present this cycle |
| pix_data_i | input | DW | Pixel value |
| ll_valid_i | input | 1 | Low-low feedback sample present |
| ll_lvl_i | input | LW | Level that produced the feedback sample (1 to LEVELS-1) |
| ll_data_i | input | DW | Feedback sample value |
| lvl_o | output | LW | Level issued this slot, 0 for a bubble |
| bubble_o | output | 1 | Idle slot |
| bank_sel_o | output | LEVELS | One-hot delay-register bank select |
| op_a_o | output | DW | Older operand of the pair |
| op_b_o | output | DW | Newer operand of the pair |
| to_next_o | output | 1 | Result feeds the next level |
| to_out_o | output | 1 | Result leaves the pyramid |

## Verification
The assertions take for granted that no queue is pushed while full, and that ll_lvl_i names a level from 1 to LEVELS-1 whenever ll_valid_i is high. The stimulus keeps within both limits. It sends at most one pixel per clock and at most one feedback sample per clock. Each feedback sample is sent the cycle after every second issue of its level, so the queues stay well below their depth. A dense frame and a sparse frame are run, and the sparse frame starves the queues so that idle slots also arise from missing operands.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_NEXT = 2'd1,
    ROUTE_OUT  = 2'd2
  } route_e;
endpackage

// File: rtl/rpa_pair_fifo.sv
module rpa_pair_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop2_i,
  output logic [DW-1:0] dout_a_o,
  output logic [DW-1:0] dout_b_o,
  output logic [CW-1:0] fill_o
);
  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + PW'(1);
      if (pop2_i) rd_q <= rd_q + PW'(2);
      fill_q <= fill_q + CW'(push_i) - (pop2_i ? CW'(2) : CW'(0));
    end
  end

  assign dout_a_o = mem_q[rd_q];
  assign dout_b_o = mem_q[rd_q + PW'(1)];
  assign fill_o   = fill_q;
endmodule

// File: rtl/rpa_slot_ctr.sv
module rpa_slot_ctr #(
  parameter int LEVELS = 3,
  localparam int LW    = $clog2(LEVELS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [LW-1:0] slot_lvl_o
);
  logic [LEVELS-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_q + LEVELS'(1);
  end

  // owner = position of lowest set bit + 1; slot 0 has no owner
  always_comb begin
    slot_lvl_o = '0;
    for (int j = LEVELS - 1; j >= 0; j--) begin
      if (slot_q[j]) slot_lvl_o = LW'(j + 1);
    end
  end
endmodule

// File: rtl/rpa_sched.sv
module rpa_sched
  import rpa_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int DW     = 8,
  parameter int DEPTH  = 8,
  localparam int LW    = $clog2(LEVELS + 1),
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic [DW-1:0]     pix_data_i,
  input  logic              ll_valid_i,
  input  logic [LW-1:0]     ll_lvl_i,
  input  logic [DW-1:0]     ll_data_i,
  output logic [LW-1:0]     lvl_o,
  output logic              bubble_o,
  output logic [LEVELS-1:0] bank_sel_o,
  output logic [DW-1:0]     op_a_o,
  output logic [DW-1:0]     op_b_o,
  output logic              to_next_o,
  output logic              to_out_o
);
  logic [LW-1:0] slot_lvl, grant_lvl;
  logic [LEVELS-1:0][CW-1:0] fill_w;
  logic [LEVELS-1:0][DW-1:0] qa_w, qb_w;
  logic [LEVELS-1:0] pop2_w;
  logic [DW-1:0] op_a_d, op_b_d;
  logic [LEVELS-1:0] bank_d;
  route_e route_d;

  rpa_slot_ctr #(.LEVELS(LEVELS)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_lvl_o (slot_lvl)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    logic          push;
    logic [DW-1:0] din;
    if (g == 0) begin : g_pix
      assign push = pix_valid_i;
      assign din  = pix_data_i;
    end else begin : g_fb
      assign push = ll_valid_i && (ll_lvl_i == LW'(g));
      assign din  = ll_data_i;
    end
    assign pop2_w[g] = (grant_lvl == LW'(g + 1));

    rpa_pair_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (push),
      .din_i    (din),
      .pop2_i   (pop2_w[g]),
      .dout_a_o (qa_w[g]),
      .dout_b_o (qb_w[g]),
      .fill_o   (fill_w[g])
    );
  end

  always_comb begin
    grant_lvl = '0;
    op_a_d    = '0;
    op_b_d    = '0;
    bank_d    = '0;
    for (int j = 0; j < LEVELS; j++) begin
      if (slot_lvl == LW'(j + 1) && fill_w[j] >= CW'(2)) begin
        grant_lvl = LW'(j + 1);
        op_a_d    = qa_w[j];
        op_b_d    = qb_w[j];
        bank_d[j] = 1'b1;
      end
    end
    if (grant_lvl == '0)                route_d = ROUTE_NONE;
    else if (grant_lvl == LW'(LEVELS))  route_d = ROUTE_OUT;
    else                                route_d = ROUTE_NEXT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o      <= '0;
      bubble_o   <= 1'b1;
      bank_sel_o <= '0;
      op_a_o     <= '0;
      op_b_o     <= '0;
      to_next_o  <= 1'b0;
      to_out_o   <= 1'b0;
    end else begin
      lvl_o      <= grant_lvl;
      bubble_o   <= (grant_lvl == '0);
      bank_sel_o <= bank_d;
      op_a_o     <= op_a_d;
      op_b_o     <= op_b_d;
      to_next_o  <= (route_d == ROUTE_NEXT);
      to_out_o   <= (route_d == ROUTE_OUT);
    end
  end
endmodule

// File: rtl/rpa_sched_chk.sv
module rpa_sched_chk #(
  parameter int LEVELS = 3,
  parameter int LW     = 2,
  parameter int CW     = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [LW-1:0]              lvl_i,
  input logic                       bubble_i,
  input logic [LEVELS-1:0]          bank_i,
  input logic                       to_next_i,
  input logic                       to_out_i,
  input logic [LEVELS-1:0][CW-1:0]  fill_i
);
  logic [LEVELS-1:0][CW-1:0] fill_q;
  logic ready_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= fill_i;
  end

  always_comb begin
    ready_ok = 1'b0;
    for (int j = 0; j < LEVELS; j++) begin
      if (lvl_i == LW'(j + 1)) ready_ok = (fill_q[j] >= CW'(2));
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (bubble_i && lvl_i == '0 && bank_i == '0 && !to_next_i && !to_out_i)
        else $error("reset outputs not idle");
    end
  end

  assert_l1_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == LW'(1)) |=> (lvl_i != LW'(1)));

  assert_operands_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_i |-> ready_ok);

  assert_bank_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_i) && (bubble_i == (bank_i == '0)));

  assert_route_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_out_i |-> (lvl_i == LW'(LEVELS)) && !to_next_i);

  assert_route_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_i |-> (to_next_i || to_out_i));

  assert_bubble_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_i == (lvl_i == '0));
endmodule

bind rpa_sched rpa_sched_chk #(.LEVELS(LEVELS), .LW(LW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lvl_i     (lvl_o),
  .bubble_i  (bubble_o),
  .bank_i    (bank_sel_o),
  .to_next_i (to_next_o),
  .to_out_i  (to_out_o),
  .fill_i    (fill_w)
);

// File: tb/rpa_sched_test.sv
module rpa_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS = 3;
  localparam int DW = 8;
  localparam int LW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_valid_i = 1'b0;
  logic [DW-1:0] pix_data_i = '0;
  logic ll_valid_i = 1'b0;
  logic [LW-1:0] ll_lvl_i = '0;
  logic [DW-1:0] ll_data_i = '0;
  logic [LW-1:0] lvl_o;
  logic bubble_o;
  logic [LEVELS-1:0] bank_sel_o;
  logic [DW-1:0] op_a_o, op_b_o;
  logic to_next_o, to_out_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  rpa_sched #(.LEVELS(LEVELS), .DW(DW), .DEPTH(8)) uut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] q1[$], q2[$], q3[$];
  int slot;
  int exp_lvl;
  logic [DW-1:0] exp_a, exp_b;
  int iss[4];
  int bubbles;
  int pix_sent;

  function automatic int qsize(int l);
    case (l)
      1: return q1.size();
      2: return q2.size();
      default: return q3.size();
    endcase
  endfunction

  function automatic logic [DW-1:0] qpop(int l);
    case (l)
      1: return q1.pop_front();
      2: return q2.pop_front();
      default: return q3.pop_front();
    endcase
  endfunction

  task automatic model_reset();
    q1.delete(); q2.delete(); q3.delete();
    slot = 0; exp_lvl = 0; exp_a = '0; exp_b = '0;
    for (int i = 0; i < 4; i++) iss[i] = 0;
    bubbles = 0;
  endtask

  task automatic check(bit ok, string req, string act, string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic compare_outputs();
    logic [LEVELS-1:0] eb;
    bit ok;
    eb = (exp_lvl == 0) ? '0 : LEVELS'(1) << (exp_lvl - 1);
    ok = (int'(lvl_o) == exp_lvl) && (bubble_o == (exp_lvl == 0)) && (bank_sel_o == eb)
      && (to_next_o == (exp_lvl != 0 && exp_lvl < LEVELS)) && (to_out_o == (exp_lvl == LEVELS));
    if (exp_lvl != 0) ok = ok && (op_a_o == exp_a) && (op_b_o == exp_b);
    // R2 slot owner, R3 readiness, R4 order, R5 bank, R6 route, R7 tag, R8 timing
    check(ok, "R2/R3/R4/R5/R6/R7/R8",
      $sformatf("lvl=%0d bub=%0b bank=%b a=%0h b=%0h nx=%0b out=%0b", lvl_o, bubble_o, bank_sel_o, op_a_o, op_b_o, to_next_o, to_out_o),
      $sformatf("lvl=%0d bank=%b a=%0h b=%0h", exp_lvl, eb, exp_a, exp_b));
  endtask

  // one clock: compare, choose inputs, advance model, drive, wait
  task automatic step(bit pv, logic [DW-1:0] pd);
    bit fb; int fl; logic [DW-1:0] fd; int owner;
    compare_outputs();
    fb = 0; fl = 0; fd = '0;
    if (exp_lvl == 0) bubbles++;
    else begin
      iss[exp_lvl]++;
      if (exp_lvl < LEVELS && iss[exp_lvl] % 2 == 0) begin
        fb = 1; fl = exp_lvl; fd = exp_a + exp_b;
      end
    end
    owner = 0;
    for (int j = LEVELS; j >= 1; j--) if (slot % (1 << j) == (1 << (j - 1))) owner = j;
    if (owner != 0 && qsize(owner) >= 2) begin
      exp_lvl = owner; exp_a = qpop(owner); exp_b = qpop(owner);
    end else exp_lvl = 0;
    // R9 routing of inputs into level queues
    if (pv) q1.push_back(pd);
    if (fb) begin
      if (fl == 1) q2.push_back(fd); else q3.push_back(fd);
    end
    slot = (slot + 1) % (1 << LEVELS);
    pix_valid_i = pv; pix_data_i = pd;
    ll_valid_i = fb; ll_lvl_i = LW'(fl); ll_data_i = fd;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    pix_valid_i = 0; ll_valid_i = 0; ll_lvl_i = '0;
    repeat (2) @(negedge clk_i);
    check(bubble_o && lvl_o == '0 && bank_sel_o == '0 && op_a_o == '0 && op_b_o == '0 && !to_next_o && !to_out_o,
      "R1", $sformatf("lvl=%0d bub=%0b bank=%b", lvl_o, bubble_o, bank_sel_o), "lvl=0 bub=1 bank=000");
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    // dense 8x8 frame, one pixel per clock
    @(negedge clk_i);
    do_reset();
    pix_sent = 0;
    for (int k = 0; k < 64; k++) step(1'b1, DW'(k * 7 + 3));
    for (int k = 0; k < 60; k++) step(1'b0, '0);
    // R10 per-level pair counts for N=8
    check(iss[1] == 32, "R10", $sformatf("%0d", iss[1]), "32");
    check(iss[2] == 8,  "R10", $sformatf("%0d", iss[2]), "8");
    check(iss[3] == 2,  "R10", $sformatf("%0d", iss[3]), "2");
    check(bubbles >= 124 / 8, "R2", $sformatf("%0d", bubbles), ">=15");

    // sparse frame: 32 pixels, one every third clock
    do_reset();
    for (int k = 0; k < 96; k++) step(k % 3 == 0, DW'(k * 5 + 1));
    for (int k = 0; k < 80; k++) step(1'b0, '0);
    check(iss[1] == 16, "R10", $sformatf("%0d", iss[1]), "16");
    check(iss[2] == 4,  "R10", $sformatf("%0d", iss[2]), "4");
    check(iss[3] == 1,  "R10", $sformatf("%0d", iss[3]), "1");
    check(q1.size() == 0 && q2.size() == 0 && q3.size() == 0, "R3",
      $sformatf("%0d/%0d/%0d", q1.size(), q2.size(), q3.size()), "0/0/0");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule